// File: doc/BRIEF.md
# Counter Enable Register with Set/Clear Views

This block keeps the on/off state for a bank of performance counters: one cycle counter and `N_EVT` event counters. Software reaches that state through a 32-bit register port that has two aliased views. A write to the set view turns on every counter whose bit is 1. A write to the clear view turns off every counter whose bit is 1. In both views a 0 bit leaves its counter as it was. Either view reads back the present enable vector. Bit 31 always stands for the cycle counter, and bits `N_EVT-1..0` stand for the event counters. The bits in between are unimplemented: they read as zero and writes to them are ignored.

Every access goes through a privilege gate. An access made in privileged mode always passes. An unprivileged access passes only while the user-access enable input is 1. A refused access leaves the state alone, returns zero read data and raises `fault` for that cycle. The block drives one enable line per counter on `cnt_en`. The cycle counter's line is the top bit.

Each access lasts one cycle. An internal decoder sorts it into one of five kinds: IDLE (no select), DENY (privilege check failed), READ, SET (write to the set view) or CLR (write to the clear view). The enable bits change only on a rising clock edge of a SET or CLR cycle.

Top module: `pmen_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, every bit of `cnt_en` is 0 and an allowed read returns 0.
- R2: A SET access (sel=1, wr=1, view_clr=0, allowed) makes each counter whose mapped `wdata` bit is 1 enabled from the next cycle. Counters whose bit is 0 keep their state.
- R3: A CLR access (sel=1, wr=1, view_clr=1, allowed) makes each counter whose mapped `wdata` bit is 1 disabled from the next cycle. Counters whose bit is 0 keep their state.
- R4: Register bit 31 maps to the cycle counter, `cnt_en[N_EVT]`. Register bit x, for x below `N_EVT`, maps to event counter x, `cnt_en[x]`. Both views and read data use this same mapping.
- R5: Register bits 30 down to `N_EVT` always read as 0, and writing them changes no enable.
- R6: With `priv`=1 an access is allowed whatever the value of `user_ok`.
- R7: With `priv`=0 and `user_ok`=1 an access is allowed and behaves as a privileged one.
- R8: With `priv`=0 and `user_ok`=0 a selected access is refused. A refused access changes no enable, gives `rdata`=0 and sets `fault`=1 in that same cycle.
- R9: During any allowed access, including a write, `rdata` shows the enable vector from before that cycle's edge. A write's effect appears in the following cycle.
- R10: With `sel`=0, `rdata` is 0, `fault` is 0 and no enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access select for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| view_clr | input | 1 | View bit: 0 = set view, 1 = clear view |
| wdata | input | 32 | Write data |
| priv | input | 1 | Access made in privileged mode |
| user_ok | input | 1 | Unprivileged access enable |
| rdata | output | 32 | Read data; current enable vector when allowed |
| fault | output | 1 | Refused access this cycle |
| cnt_en | output | N_EVT+1 | Counter enables; top bit is the cycle counter |

## Verification
An enable bit held in the wrong state shows on `cnt_en` in the cycle right after the edge that stored it. The same wrong bit is visible on `rdata` at the next allowed access, so a mismatch appears within one cycle. A broken privilege gate shows in the same cycle as the access, as a missing or spurious `fault` or as non-zero read data on a refused access. A bit that was mapped or masked wrongly shows either as a set bit in the reserved field of `rdata` or as the wrong line of `cnt_en` moving.

// File: rtl/pmen_pkg.sv
package pmen_pkg;

    localparam int REG_W   = 32;
    localparam int CYC_POS = 31;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_DENY,
        ACC_READ,
        ACC_SET,
        ACC_CLR
    } acc_e;

endpackage

// File: rtl/pmen_gate.sv
module pmen_gate
    import pmen_pkg::*;
(
    input  logic sel,
    input  logic wr,
    input  logic view_clr,
    input  logic priv,
    input  logic user_ok,
    output acc_e kind
);

    logic allowed;

    assign allowed = priv | user_ok;

    always_comb begin
        if (!sel) begin
            kind = ACC_IDLE;
        end else if (!allowed) begin
            kind = ACC_DENY;
        end else if (!wr) begin
            kind = ACC_READ;
        end else if (view_clr) begin
            kind = ACC_CLR;
        end else begin
            kind = ACC_SET;
        end
    end

endmodule

// File: rtl/pmen_bits.sv
module pmen_bits
    import pmen_pkg::*;
#(
    parameter int N_EVT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             kind,
    input  logic [REG_W-1:0] wdata,
    output logic [N_EVT:0]   en
);

    localparam int EW = N_EVT + 1;

    logic [EW-1:0] pick;

    assign pick = {wdata[CYC_POS], wdata[N_EVT-1:0]};

    generate
        if (N_EVT < CYC_POS) begin : g_rsv
            logic unused_rsv;
            assign unused_rsv = ^wdata[CYC_POS-1:N_EVT];
        end
    endgenerate

    generate
        for (genvar i = 0; i < EW; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en[i] <= 1'b0;
                end else begin
                    unique case (kind)
                        ACC_SET: if (pick[i]) en[i] <= 1'b1;
                        ACC_CLR: if (pick[i]) en[i] <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pmen_view.sv
module pmen_view
    import pmen_pkg::*;
#(
    parameter int N_EVT = 6
) (
    input  logic [N_EVT:0]   en,
    input  logic             show,
    output logic [REG_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (show) begin
            rdata[CYC_POS]     = en[N_EVT];
            rdata[N_EVT-1:0]   = en[N_EVT-1:0];
        end
    end

endmodule

// File: rtl/pmen_ctrl.sv
module pmen_ctrl
    import pmen_pkg::*;
#(
    parameter int N_EVT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              view_clr,
    input  logic [31:0]       wdata,
    input  logic              priv,
    input  logic              user_ok,
    output logic [31:0]       rdata,
    output logic              fault,
    output logic [N_EVT:0]    cnt_en
);

    acc_e kind;
    logic show;

    pmen_gate u_gate (
        .sel      (sel),
        .wr       (wr),
        .view_clr (view_clr),
        .priv     (priv),
        .user_ok  (user_ok),
        .kind     (kind)
    );

    pmen_bits #(.N_EVT(N_EVT)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (wdata),
        .en    (cnt_en)
    );

    always_comb begin
        unique case (kind)
            ACC_READ, ACC_SET, ACC_CLR: show = 1'b1;
            default:                    show = 1'b0;
        endcase
    end

    assign fault = (kind == ACC_DENY);

    pmen_view #(.N_EVT(N_EVT)) u_view (
        .en    (cnt_en),
        .show  (show),
        .rdata (rdata)
    );

endmodule

// File: rtl/pmen_chk.sv
module pmen_chk #(
    parameter int N_EVT = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sel,
    input logic           wr,
    input logic           view_clr,
    input logic [31:0]    wdata,
    input logic           priv,
    input logic           user_ok,
    input logic [31:0]    rdata,
    input logic           fault,
    input logic [N_EVT:0] cnt_en
);

    localparam logic [31:0] IMPL = 32'h8000_0000 | 32'((64'd1 << N_EVT) - 64'd1);

    logic [N_EVT:0] wmask;
    logic           ok;

    assign wmask = {wdata[31], wdata[N_EVT-1:0]};
    assign ok    = priv | user_ok;

    // R2
    set_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && ok && !view_clr) |=> cnt_en == ($past(cnt_en) | $past(wmask)));

    // R3
    clr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && ok && view_clr) |=> cnt_en == ($past(cnt_en) & ~$past(wmask)));

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~IMPL) == 32'h0);

    // R8
    deny_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !ok) |=> $stable(cnt_en));

    // R8
    deny_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !ok) |-> (fault && rdata == 32'h0));

    // R9
    read_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && ok) |-> ({rdata[31], rdata[N_EVT-1:0]} == cnt_en && !fault));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(cnt_en)));

    // R10
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == 32'h0 && !fault));

endmodule

bind pmen_ctrl pmen_chk #(.N_EVT(N_EVT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr       (wr),
    .view_clr (view_clr),
    .wdata    (wdata),
    .priv     (priv),
    .user_ok  (user_ok),
    .rdata    (rdata),
    .fault    (fault),
    .cnt_en   (cnt_en)
);

// File: tb/test_pmen_ctrl.sv
`timescale 1ns/1ps
module test_pmen_ctrl;

    localparam int N = 6;
    localparam logic [31:0] IMPL = 32'h8000_0000 | 32'((64'd1 << N) - 64'd1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, view_clr = 1'b0, priv = 1'b0, user_ok = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fault;
    logic [N:0]  cnt_en;

    int total = 0;
    int fails = 0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    pmen_ctrl #(.N_EVT(N)) i_pmen_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .view_clr(view_clr),
        .wdata(wdata), .priv(priv), .user_ok(user_ok),
        .rdata(rdata), .fault(fault), .cnt_en(cnt_en)
    );

    function automatic logic [31:0] lines(logic [31:0] v);
        logic [31:0] r = '0;
        r[N] = v[31];
        for (int i = 0; i < N; i++) r[i] = v[i];
        return r;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(string req, bit s, bit w, bit c, logic [31:0] d, bit p, bit u);
        bit allowed;
        @(negedge clk);
        sel = s; wr = w; view_clr = c; wdata = d; priv = p; user_ok = u;
        #1;
        allowed = p | u;
        chk(req, "rdata", rdata, (s && allowed) ? model : 32'h0);
        chk(req, "fault", {31'h0, fault}, {31'h0, s && !allowed});
        chk(req, "cnt_en", {{(31-N){1'b0}}, cnt_en}, lines(model));
        @(posedge clk);
        if (s && allowed && w) begin
            if (c) model = model & ~(d & IMPL);
            else   model = model | (d & IMPL);
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "cnt_en in reset", {{(31-N){1'b0}}, cnt_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 1, 0, 0, 32'h0, 1, 0);
        step("R10", 0, 1, 0, 32'hFFFF_FFFF, 1, 1);
        step("R10", 0, 0, 0, 32'h0, 1, 0);
        // all ones to set view: reserved bits must stay zero
        step("R5", 1, 1, 0, 32'hFFFF_FFFF, 1, 0);
        step("R5", 1, 0, 0, 32'h0, 1, 0);
        step("R3", 1, 1, 1, 32'hFFFF_FFFF, 1, 0);
        // cycle counter bit alone
        step("R4", 1, 1, 0, 32'h8000_0000, 1, 0);
        step("R4", 1, 0, 0, 32'h0, 1, 0);
        step("R4", 1, 1, 0, 32'h0000_0005, 1, 0);
        step("R2", 1, 1, 0, 32'h0, 1, 0);
        step("R3", 1, 1, 1, 32'h0000_0004, 1, 0);
        step("R3", 1, 1, 1, 32'h0, 1, 0);
        step("R5", 1, 1, 0, 32'h7FFF_FFC0, 1, 0);
        step("R9", 1, 1, 0, 32'h0000_0002, 1, 0);
        step("R9", 1, 0, 0, 32'h0, 1, 0);
        // refused accesses
        step("R8", 1, 1, 0, 32'hFFFF_FFFF, 0, 0);
        step("R8", 1, 1, 1, 32'hFFFF_FFFF, 0, 0);
        step("R8", 1, 0, 0, 32'h0, 0, 0);
        step("R7", 1, 1, 1, 32'h8000_0001, 0, 1);
        step("R7", 1, 0, 0, 32'h0, 0, 1);
        step("R6", 1, 1, 0, 32'h0000_0030, 1, 1);
        step("R6", 1, 0, 0, 32'h0, 1, 0);
        for (int k = 0; k < 300; k++) begin
            logic [31:0] d = $urandom;
            logic [3:0]  ctl = 4'($urandom);
            step("R2", ctl[3] | ctl[2], ctl[0], ctl[1], d, ctl[2], ctl[3]);
        end
        step("R10", 0, 0, 0, 32'h0, 0, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule